// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block takes one character at a time from a host and sends it as an asynchronous frame on a single serial output line. The frame shape is chosen at run time. The character length is 5 to 8 bits. Parity may be none, odd or even. The stop interval is 1, 1.5 or 2 bit times. A baud factor sets how many transmit-clock periods make up one bit time.

The host writes a character into a one-entry holding buffer. A ready flag shows when that buffer is empty. The frame engine moves the buffered character into its own shift register only when the transmit enable input is high and the active-low clear-to-send input is low. The engine then serializes the character while the host refills the buffer. Frames can therefore run back to back with no idle bit between them.

All state advances on the rising edge of the transmit clock. The serial line itself is re-registered on the falling edge of that clock, so the line moves half a period after the state that drives it.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 (mark) and, after reset, `tx_rdy` is 1.
- R2: A frame starts only at a rising clock edge where `tx_en` is 1, `cts_n` is 0 and the holding buffer is full. While either gate is closed, `txd` stays 1 and the buffered character is kept.
- R3: A frame is one start bit (0), then the data bits least significant first, then the parity bit if enabled, then stop bits (1).
- R4: `len_sel` encodes the character length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 bits. Data bits above the chosen length are not sent.
- R5: `par_sel` encodes parity: 1 = odd, 2 = even, 0 or 3 = none. Parity covers only the sent data bits. With odd parity, the data ones plus the parity bit total an odd number; with even parity, they total an even number.
- R6: `stop_sel` encodes the stop interval: 0 = 1 bit time, 1 = 1.5 bit times (24 clocks at factor 16, 96 clocks at factor 64), 2 or 3 = 2 bit times. With factor 1, code 1 gives 2 bit times.
- R7: `baud_sel` encodes the clocks per bit time: 0 = 1, 1 = 16, 2 or 3 = 64.
- R8: `txd` changes only on the falling edge of `clk`. The start bit appears half a clock period after the rising edge that starts the frame.
- R9: `tx_rdy` is 1 exactly while the holding buffer is empty. A write while `tx_rdy` is 0 is ignored. A character buffered during a frame starts on the clock right after that frame's last stop clock.
- R10: If `cts_n` goes to 1 during a frame, that frame still completes. No further frame starts until `cts_n` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable control bit |
| cts_n | input | 1 | Clear-to-send, active low |
| len_sel | input | 2 | Character length code |
| par_sel | input | 2 | Parity mode code |
| stop_sel | input | 2 | Stop interval code |
| baud_sel | input | 2 | Clocks-per-bit code |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host character |
| tx_rdy | output | 1 | Holding buffer empty |
| txd | output | 1 | Serial data line |

## Verification
A write taken at rising edge E clears `tx_rdy` just after E. If the gates are open, the frame begins at edge E+1. The start bit then shows on `txd` after the falling edge that follows E+1, and each bit holds for exactly the programmed number of clocks.

The bench therefore drives inputs 1 ns after a rising edge and samples `txd` 3 ns after it, just past the falling edge. It compares the line against the expected value at every clock of each frame. It also checks that the line has not yet moved 1 ns after the starting edge. Frame length, including the 1.5-bit stop, is checked by queuing a second character and requiring its start bit exactly one computed frame length after the first.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic [1:0] par_sel;
    logic [1:0] stop_sel;
    logic [1:0] baud_sel;
  } frame_cfg_t;

  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd2;

endpackage

// File: rtl/txs_hold_buf.sv
module txs_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] data
);

  // one-entry buffer; a write while full is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      data  <= '0;
    end else if (take) begin
      empty <= 1'b1;
    end else if (wr_en && empty) begin
      empty <= 1'b0;
      data  <= wr_data;
    end
  end

endmodule

// File: rtl/txs_frame_fsm.sv
module txs_frame_fsm
  import serial_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_cfg_t        cfg,
  input  logic              gate_ok,
  input  logic              have_char,
  input  logic [DATA_W-1:0] char_in,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);

  localparam int LEN_W = $clog2(DATA_W + 1);

  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic [LEN_W-1:0]  bits_left;
  logic              par_q;

  function automatic logic [CNT_W-1:0] bit_len(input logic [1:0] b);
    case (b)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(FACTOR_MID);
      default: return CNT_W'(FACTOR_HI);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stop_len(input logic [1:0] s, input logic [1:0] b);
    logic [CNT_W-1:0] l;
    l = bit_len(b);
    case (s)
      2'd0:    return l;
      2'd1:    return (b == 2'd0) ? (l << 1) : (l + (l >> 1));
      default: return l << 1;
    endcase
  endfunction

  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] masked;
  logic              bit_end;
  logic              par_en_q;
  logic [CNT_W-1:0]  bl_q;
  logic [CNT_W-1:0]  sl_q;

  always_comb begin
    nbits = LEN_W'(MIN_LEN) + LEN_W'(cfg.len_sel);
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = char_in[i] & (32'(nbits) > i);
    end
  end

  assign bit_end  = (cnt == '0);
  assign par_en_q = (cfg_q.par_sel == PAR_ODD) || (cfg_q.par_sel == PAR_EVEN);
  assign bl_q     = bit_len(cfg_q.baud_sel);
  assign sl_q     = stop_len(cfg_q.stop_sel, cfg_q.baud_sel);
  assign busy     = (state != ST_IDLE);
  assign take     = have_char && gate_ok &&
                    ((state == ST_IDLE) || ((state == ST_STOP) && bit_end));

  always_comb begin
    case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = sr[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      cnt       <= '0;
      sr        <= '0;
      bits_left <= '0;
      par_q     <= 1'b0;
    end else if (take) begin
      state     <= ST_START;
      cfg_q     <= cfg;
      cnt       <= bit_len(cfg.baud_sel) - 1'b1;
      sr        <= masked;
      bits_left <= nbits;
      par_q     <= (cfg.par_sel == PAR_ODD) ? ~(^masked) : (^masked);
    end else if (state != ST_IDLE) begin
      if (!bit_end) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (state)
          ST_START: begin
            state <= ST_DATA;
            cnt   <= bl_q - 1'b1;
          end
          ST_DATA: begin
            sr        <= sr >> 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == LEN_W'(1)) begin
              state <= par_en_q ? ST_PAR : ST_STOP;
              cnt   <= par_en_q ? (bl_q - 1'b1) : (sl_q - 1'b1);
            end else begin
              cnt <= bl_q - 1'b1;
            end
          end
          ST_PAR: begin
            state <= ST_STOP;
            cnt   <= sl_q - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/txs_line_reg.sv
module txs_line_reg (
  input  logic clk,
  input  logic rst,
  input  logic line_bit,
  output logic txd
);

  // serial line moves on the falling edge of the transmit clock
  always_ff @(negedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= line_bit;
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        par_sel,
  input  logic [1:0]        stop_sel,
  input  logic [1:0]        baud_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_rdy,
  output logic              txd
);

  localparam int CNT_W = $clog2(2 * FACTOR_HI) + 1;

  frame_cfg_t        cfg;
  logic              take;
  logic              busy;
  logic              line_bit;
  logic              hold_empty;
  logic [DATA_W-1:0] hold_data;

  assign cfg    = '{len_sel: len_sel, par_sel: par_sel, stop_sel: stop_sel, baud_sel: baud_sel};
  assign tx_rdy = hold_empty;

  txs_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .empty   (hold_empty),
    .data    (hold_data)
  );

  txs_frame_fsm #(
    .DATA_W     (DATA_W),
    .MIN_LEN    (MIN_LEN),
    .FACTOR_MID (FACTOR_MID),
    .FACTOR_HI  (FACTOR_HI),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .gate_ok   (tx_en && !cts_n),
    .have_char (!hold_empty),
    .char_in   (hold_data),
    .take      (take),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  txs_line_reg u_line (
    .clk      (clk),
    .rst      (rst),
    .line_bit (line_bit),
    .txd      (txd)
  );

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic cts_n,
  input logic wr_en,
  input logic tx_rdy,
  input logic txd,
  input logic busy
);

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(tx_en) && !$past(cts_n)));

  // R2
  hold_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_rdy && !(tx_en && !cts_n)) |=> !tx_rdy);

  // R9
  fill_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_rdy && wr_en) |=> !tx_rdy);

  // R9
  no_self_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_rdy && !wr_en) |=> tx_rdy);

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tx_en  (tx_en),
  .cts_n  (cts_n),
  .wr_en  (wr_en),
  .tx_rdy (tx_rdy),
  .txd    (txd),
  .busy   (busy)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       cts_n = 1'b1;
  logic [1:0] len_sel = 2'd0;
  logic [1:0] par_sel = 2'd0;
  logic [1:0] stop_sel = 2'd0;
  logic [1:0] baud_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_rdy;
  logic       txd;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_frame_tx u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cts_n(cts_n),
    .len_sel(len_sel), .par_sel(par_sel), .stop_sel(stop_sel), .baud_sel(baud_sel),
    .wr_en(wr_en), .wr_data(wr_data), .tx_rdy(tx_rdy), .txd(txd)
  );

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic [1:0] stop;
    logic [1:0] baud;
    logic [7:0] data;
    logic       pbit;   // hand-computed parity bit
    int         frame;  // hand-computed frame length in clocks
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 2'd0, 2'd0, 2'd0, 8'hA5, 1'b0, 10},
    '{2'd0, 2'd1, 2'd2, 2'd0, 8'h1F, 1'b0, 9},
    '{2'd2, 2'd2, 2'd1, 2'd1, 8'hFF, 1'b1, 168},
    '{2'd1, 2'd2, 2'd0, 2'd1, 8'hC3, 1'b0, 144},
    '{2'd3, 2'd1, 2'd1, 2'd0, 8'h00, 1'b1, 12},
    '{2'd3, 2'd0, 2'd3, 2'd2, 8'h3C, 1'b0, 704},
    '{2'd0, 2'd1, 2'd1, 2'd3, 8'hE4, 1'b0, 544},
    '{2'd1, 2'd3, 2'd0, 2'd0, 8'h2A, 1'b0, 8}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic exp_bit(input vec_t v, input int c);
    int l, n, k;
    bit p;
    l = (v.baud == 2'd0) ? 1 : (v.baud == 2'd1) ? 16 : 64;
    n = 5 + int'(v.len);
    p = (v.par == 2'd1) || (v.par == 2'd2);
    if (c < l) return 1'b0;
    k = c / l - 1;
    if (k < n) return v.data[k];
    if (p && k == n) return v.pbit;
    return 1'b1;
  endfunction

  // starts 1 ns after the edge that began the frame; c counts clocks
  task automatic watch(input vec_t v, input int upto, input int second_at, input string tag);
    for (int c = 0; c < upto; c++) begin
      #2;
      if (c == second_at) check({tag, " next start"}, txd, 1'b0);
      else if (c < v.frame) check(tag, txd, exp_bit(v, c));
      else check({tag, " idle"}, txd, 1'b1);
      tick();
      if (c == 0) wr_en = 1'b0;
    end
  endtask

  task automatic set_cfg(input vec_t v);
    len_sel = v.len; par_sel = v.par; stop_sel = v.stop; baud_sel = v.baud;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t g;
    repeat (5) tick();
    rst = 1'b0;
    tick();
    check("R1 reset txd", txd, 1'b1);
    check("R1 reset tx_rdy", tx_rdy, 1'b1);

    // table walk: R3 R4 R5 R6 R7 R8 R9 with back-to-back second character
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i]);
      tx_en = 1'b1; cts_n = 1'b0;
      wr_en = 1'b1; wr_data = VECS[i].data;
      tick();
      wr_en = 1'b0;
      check("R9 full after write", tx_rdy, 1'b0);
      tick();
      check("R8 line not moved before falling edge", txd, 1'b1);
      check("R9 empty after start", tx_rdy, 1'b1);
      wr_en = 1'b1;
      watch(VECS[i], VECS[i].frame + 1, VECS[i].frame, "R3 R4 R5 R6 R7 frame");
      repeat (VECS[i].frame + 2) tick();
      #2;
      check("R1 idle after frames", txd, 1'b1);
      check("R9 empty at end", tx_rdy, 1'b1);
      tick();
    end

    // R2 gates and R9 ignored write
    g = '{2'd3, 2'd0, 2'd0, 2'd0, 8'h3C, 1'b0, 10};
    set_cfg(g);
    tx_en = 1'b0; cts_n = 1'b0;
    wr_en = 1'b1; wr_data = 8'h3C;
    tick();
    wr_data = 8'hC3;
    tick();
    wr_en = 1'b0;
    for (int c = 0; c < 20; c++) begin
      #2;
      check("R2 tx_en low holds line", txd, 1'b1);
      check("R2 char kept", tx_rdy, 1'b0);
      tick();
    end
    tx_en = 1'b1; cts_n = 1'b1;
    for (int c = 0; c < 20; c++) begin
      #2;
      check("R2 cts high holds line", txd, 1'b1);
      tick();
    end
    cts_n = 1'b0;
    tick();
    check("R8 start after falling edge only", txd, 1'b1);
    watch(g, 20, -1, "R9 first char sent, second ignored");
    check("R9 ready after ignored write", tx_rdy, 1'b1);

    // R10 clear-to-send dropped mid-frame
    g.data = 8'h5A;
    wr_en = 1'b1; wr_data = 8'h5A;
    tick();
    wr_en = 1'b0;
    tick();
    cts_n = 1'b1;
    wr_en = 1'b1; wr_data = 8'h96;
    watch(g, 30, -1, "R10 frame completes");
    check("R10 next char waits", tx_rdy, 1'b0);
    cts_n = 1'b0;
    tick();
    g.data = 8'h96;
    watch(g, 14, -1, "R10 resumes after cts");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule